// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four asynchronous external interrupt pins before they reach the interrupt grouping logic. Each pin passes through a two-flop synchronizer. A per-pin 2-bit sense code then selects how the pin is detected:

| Code | Detection |
|------|-----------|
| 0 | Active-high level |
| 1 | Rising edge |
| 2 | Falling edge |
| 3 | Active-low level |

In the two level modes the request tracks the synchronized pin. In the two edge modes a detected edge sets a sticky latch. The latch holds until software writes one to that pin's clear bit.

Every setting lives in a single 32-bit control word, written and read through a simple port:

| Bits | Meaning |
|------|---------|
| 23:16 | Interleaved sense fields, pin 0 in the highest pair |
| 11:8 | Per-pin enables, descending with the pin number |
| 27:24 | Write-one-to-clear bits, descending with the pin number |
| 12 | Master enable |
| 0 | Critical-routing flag, stored only |

Pin 0 drives the critical-group request. Pins 1 to 3 drive main-group sources 1 to 3.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control word reads 0x0000_1001: master enable and routing flag set, every pin disabled, every sense code 0. All requests are low.
- R2: A write stores bits 23:16, 12, 11:8 and bit 0, and they read back in the next cycle. Every other bit reads 0, and the clear bits 27:24 always read 0.
- R3: With sense code 0 (field bits 23-2n:22-2n for pin n), an enabled pin's request equals the pin delayed by two clock edges.
- R4: With sense code 3, an enabled pin's request is the inverse of the synchronized pin.
- R5: With sense code 1, a rising edge on the synchronized pin sets a request that stays high while no clear is written.
- R6: With sense code 2, a falling edge on the synchronized pin sets a sticky request in the same way.
- R7: Writing 1 to bit 27-n clears the latched request of pin n only. The other latches are left as they were.
- R8: A request is asserted only when the pin's enable bit 11-n and master bit 12 are both 1. A request that is held off this way produces no output.
- R9: When a clear write and a newly detected edge for the same pin fall in the same cycle, the latch ends up set.
- R10: Pin 0 drives `crit_req`. Pins 1, 2 and 3 drive `main_req[0]`, `main_req[1]` and `main_req[2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Raw asynchronous external interrupt pins |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| crit_req | output | 1 | Critical-group request from pin 0 |
| main_req | output | 3 | Main-group requests from pins 1 to 3 |

## Verification
The assertions assume the pins hold each value for at least three cycles, so the level-follow property can compare the request with the pin two edges back. The stimulus honours this by always waiting four cycles after moving a pin, except in the deliberate two-cycle latency probe. The stickiness property assumes that nothing but a write can remove a latched edge request. The bench changes sense codes only with the pins idle, so that no mode switch creates or hides an edge.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NPINS = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    pin_i,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          crit_req,
  output logic [2:0]    main_req
);
  localparam int SENSE_LO0  = 22;
  localparam int EN_BIT0    = 11;
  localparam int CLR_BIT0   = 27;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;
  localparam logic [1:0] M_HIGH = 2'd0, M_RISE = 2'd1, M_FALL = 2'd2, M_LOW = 2'd3;

  logic             master_q, route_q;
  logic [NPINS-1:0] en_v, req_v;
  logic [1:0]       mode_v [NPINS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      master_q <= 1'b1;
      route_q  <= 1'b1;
    end else if (wr_en) begin
      master_q <= wr_data[MASTER_BIT];
      route_q  <= wr_data[ROUTE_BIT];
    end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [1:0] mode_q;
    logic       en_q, s1, s2, s3, lat_q;
    wire        edge_set = (mode_q == M_RISE && s2 && !s3) ||
                           (mode_q == M_FALL && !s2 && s3);
    wire        clr      = wr_en && wr_data[CLR_BIT0-n];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        {s1, s2, s3} <= 3'b000;
        mode_q       <= M_HIGH;
        en_q         <= 1'b0;
        lat_q        <= 1'b0;
      end else begin
        s1 <= pin_i[n];
        s2 <= s1;
        s3 <= s2;
        if (wr_en) begin
          mode_q <= wr_data[SENSE_LO0-2*n +: 2];
          en_q   <= wr_data[EN_BIT0-n];
        end
        if (edge_set)  lat_q <= 1'b1;
        else if (clr)  lat_q <= 1'b0;
      end

    wire lvl = (mode_q == M_HIGH) ? s2 :
               (mode_q == M_LOW)  ? !s2 : lat_q;

    assign req_v[n]  = lvl && en_q && master_q;
    assign en_v[n]   = en_q;
    assign mode_v[n] = mode_q;
  end

  always_comb begin
    rd_data             = '0;
    rd_data[MASTER_BIT] = master_q;
    rd_data[ROUTE_BIT]  = route_q;
    for (int i = 0; i < NPINS; i++) begin
      rd_data[SENSE_LO0-2*i +: 2] = mode_v[i];
      rd_data[EN_BIT0-i]          = en_v[i];
    end
  end

  assign crit_req = req_v[0];
  assign main_req = req_v[NPINS-1:1];
endmodule

module ext_irq_sense_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  pin_i,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        crit_req,
  input logic [2:0]  main_req
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  // R8
  crit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_req |-> (rd_data[12] && rd_data[11]));

  // R10
  main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_req[2] |-> (rd_data[12] && rd_data[8]));

  // R2
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:24] == 8'h00);

  // R5
  rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_req && rd_data[23:22] == 2'd1 && !wr_en) |=> crit_req);

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && rd_data[23:22] == 2'd0 && rd_data[12] && rd_data[11] &&
     pin_i[0] == $past(pin_i[0]) && $past(pin_i[0]) == $past(pin_i[0], 2))
    |-> crit_req == pin_i[0]);
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (.*);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_i = 4'h0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        crit_req;
  logic [2:0]  main_req;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (.*);

  wire [3:0] req = {main_req, crit_req};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg(input logic [1:0] m, input logic [3:0] en, input logic mst);
    logic [31:0] w = 32'h1;
    for (int i = 0; i < 4; i++) begin
      w[22-2*i +: 2] = m;
      w[11-i]        = en[i];
    end
    w[12] = mst;
    return w;
  endfunction

  function automatic logic [3:0] exp_req(input logic [1:0] m, input logic [3:0] p,
                                         input logic [3:0] lat);
    case (m)
      2'd0:    return p;
      2'd3:    return ~p;
      default: return lat;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] lat;
    string tag;
    idle(2);
    chk("R1 reset ctrl", rd_data, 32'h0000_1001);
    chk("R1 reset req", {28'h0, req}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    wr(32'hFFFF_FFFF);
    chk("R2 readback ones", rd_data, 32'h00FF_1F01);
    wr(32'hA5C3_5A3C);
    chk("R2 readback mixed", rd_data, 32'h00C3_1A00);
    wr(32'h0);
    chk("R2 readback zero", rd_data, 32'h0);

    for (int m = 0; m < 4; m++) begin
      case (m)
        0: tag = "R3";
        1: tag = "R5";
        2: tag = "R6";
        default: tag = "R4";
      endcase
      pin_i = 4'h0;
      wr(cfg(m[1:0], 4'hF, 1'b1));
      idle(4);
      wr(cfg(m[1:0], 4'hF, 1'b1) | 32'h0F00_0000);
      lat = 4'h0;
      chk({tag, " idle"}, {28'h0, req}, {28'h0, exp_req(m[1:0], pin_i, lat)});
      for (int n = 0; n < 4; n++) begin
        pin_i[n] = 1'b1;
        idle(4);
        if (m == 1) lat[n] = 1'b1;
        chk({tag, " pin high"}, {28'h0, req}, {28'h0, exp_req(m[1:0], pin_i, lat)});
        pin_i[n] = 1'b0;
        idle(4);
        if (m == 2) lat[n] = 1'b1;
        chk({tag, " pin low"}, {28'h0, req}, {28'h0, exp_req(m[1:0], pin_i, lat)});
      end
      if (m == 1 || m == 2)
        for (int n = 0; n < 4; n++) begin
          wr(cfg(m[1:0], 4'hF, 1'b1) | (32'h1 << (27 - n)));
          lat[n] = 1'b0;
          chk("R7 single clear", {28'h0, req}, {28'h0, lat});
        end
    end

    // R3 latency: two edges from pin to request
    wr(cfg(2'd0, 4'hF, 1'b1));
    pin_i = 4'h0; idle(4);
    pin_i = 4'h2;
    @(negedge clk);
    chk("R3 after one edge", {28'h0, req}, 32'h0);
    @(negedge clk);
    chk("R3 after two edges", {28'h0, req}, 32'h2);

    // R8 gating
    pin_i = 4'hF; idle(4);
    wr(cfg(2'd0, 4'hF, 1'b0));
    chk("R8 master off", {28'h0, req}, 32'h0);
    wr(cfg(2'd0, 4'b0100, 1'b1));
    chk("R8 one enable", {28'h0, req}, 32'h4);

    // R10 routing
    wr(cfg(2'd0, 4'hF, 1'b1));
    pin_i = 4'h1; idle(4);
    chk("R10 crit from pin0", {31'h0, crit_req}, 32'h1);
    chk("R10 main quiet", {29'h0, main_req}, 32'h0);
    pin_i = 4'h8; idle(4);
    chk("R10 main from pin3", {29'h0, main_req}, 32'h4);
    chk("R10 crit quiet", {31'h0, crit_req}, 32'h0);

    // R9 set beats clear in same cycle
    pin_i = 4'h0;
    wr(cfg(2'd1, 4'hF, 1'b1));
    idle(4);
    wr(cfg(2'd1, 4'hF, 1'b1) | 32'h0F00_0000);
    @(negedge clk); pin_i[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_data = cfg(2'd1, 4'hF, 1'b1) | 32'h0400_0000; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    idle(1);
    chk("R9 set wins", {28'h0, req}, 32'h2);
    wr(cfg(2'd1, 4'hF, 1'b1) | 32'h0400_0000);
    chk("R7 later clear", {28'h0, req}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule